// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Each guess comes from a small saturating counter. The counter is chosen by two things together: a few low bits of the branch address, and a short shift register holding the outcomes of the most recent branches. The history value picks one of several counter banks, and the address bits pick a row inside that bank.

The fetch side presents a branch address on the lookup port and receives a direction guess combinationally, in the same cycle. Later the execute side reports the resolved branch address and its real outcome on the update port. The block then trains the one counter that the address and the current history select, and shifts the outcome into the history. No tag is stored, so two branches that map to the same row and history share a counter.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 01 and the history is all zeros, so every lookup predicts not taken until training begins.
- R2: A counter whose most significant bit is 1 (values 10 and 11) yields a taken prediction (`lk_taken` = 1); values 00 and 01 yield not taken (`lk_taken` = 0).
- R3: The selected entry is bank = current history value, row = `pc[5:2]` (address bits from bit 2 upward, 4 bits by default); the flat index is {history, row}.
- R4: An update with `up_taken` = 1 raises the selected counter by one, and a counter already at 11 stays at 11.
- R5: An update with `up_taken` = 0 lowers the selected counter by one, and a counter already at 00 stays at 00.
- R6: A counter in a strong state flips its prediction only after two updates against it; one contrary outcome leaves the prediction unchanged.
- R7: An update changes only the counter at {history, row}; every counter in other rows and other banks keeps its value.
- R8: An update indexes the table with the history as it stands before that update, then shifts the outcome into history bit 0 and moves the older bits up by one.
- R9: Address bits outside the row field do not affect selection: addresses that differ only there read and train the same counter.
- R10: When a lookup and an update select the same entry in one cycle, the lookup returns the value from before that update.
- R11: With `up_valid` low, no counter and no history bit changes, whatever `up_pc`, `up_taken` and `lk_pc` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Direction guess for `lk_pc`, 1 = taken |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The bench builds the block with its default parameters: two history bits, two-bit counters, four row bits and a 32-bit address. At that size the table has only 64 counters. After every training step the bench reads all 16 rows under the live history value, and a long pseudo-random stream of outcomes moves the history through all four banks, so every counter is compared with an arithmetic model many times. The same size makes the directed sequences short: two contrary outcomes needed to flip a prediction, saturation at both ends, aliasing through high address bits, and a read and a write to the same entry in one cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Weakly-not-taken start value for a counter of the given width.
    function automatic int unsigned weak_nt(input int unsigned ctr_w);
        return (1 << (ctr_w - 1)) - 1;
    endfunction

    // Width of the flat table index.
    function automatic int unsigned table_idx_w(input int unsigned hist_w,
                                                input int unsigned row_w);
        return hist_w + row_w;
    endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int unsigned HIST_W = 2,
    parameter int unsigned ROW_W  = 4,
    parameter int unsigned PC_W   = 32,
    parameter int unsigned PC_LSB = 2,
    localparam int unsigned IDX_W = bp_pkg::table_idx_w(HIST_W, ROW_W)
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [PC_W-1:0]   pc,
    output logic [IDX_W-1:0]  idx
);

    logic [ROW_W-1:0] row;

    always_comb begin
        row = pc[PC_LSB +: ROW_W];
        idx = {hist, row};
    end

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter int unsigned HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_q
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } gh_state_t;

    gh_state_t st_d, st_q;
    logic [HIST_W:0] widened;

    always_comb begin
        st_d    = st_q;
        widened = {st_q.hist, bit_in};
        if (shift_en) begin
            st_d.hist = widened[HIST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_q = st_q.hist;

    assert_newest_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[0] == $past(bit_in));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

    generate
        if (HIST_W > 1) begin : g_older
            assert_older_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
        end
    endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CTR_W = 2,
    localparam int unsigned ENTRIES = 1 << IDX_W,
    localparam logic [CTR_W-1:0] CTR_MAX  = '1,
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(bp_pkg::weak_nt(CTR_W))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [CTR_W-1:0] ctr_d [ENTRIES];
    logic [CTR_W-1:0] ctr_q [ENTRIES];
    logic [CTR_W-1:0] old_val;
    logic [CTR_W-1:0] new_val;

    always_comb begin
        ctr_d   = ctr_q;
        old_val = ctr_q[wr_idx];
        new_val = old_val;
        if (wr_taken) begin
            if (old_val != CTR_MAX) new_val = old_val + 1'b1;
        end else begin
            if (old_val != '0) new_val = old_val - 1'b1;
        end
        if (wr_en) begin
            ctr_d[wr_idx] = new_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // Read sees registered state only: a same-cycle write is not visible.
    assign rd_ctr = ctr_q[rd_idx];

    assert_cap_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);

    assert_floor_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] == '0) |=> ctr_q[$past(wr_idx)] == '0);

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] != CTR_MAX)
        |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 1'b1);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] != '0)
        |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) - 1'b1);

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_keep
            assert_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == IDX_W'(e)) |=> $stable(ctr_q[e]));
        end
    endgenerate

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
    parameter int unsigned HIST_W = 2,
    parameter int unsigned CTR_W  = 2,
    parameter int unsigned ROW_W  = 4,
    parameter int unsigned PC_W   = 32,
    parameter int unsigned PC_LSB = 2,
    localparam int unsigned IDX_W = bp_pkg::table_idx_w(HIST_W, ROW_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    logic [CTR_W-1:0]  lk_ctr;

    bp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist_q   (hist_q)
    );

    bp_index #(.HIST_W(HIST_W), .ROW_W(ROW_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_lk_index (
        .hist (hist_q),
        .pc   (lk_pc),
        .idx  (lk_idx)
    );

    // Update uses the history before this outcome is shifted in.
    bp_index #(.HIST_W(HIST_W), .ROW_W(ROW_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_up_index (
        .hist (hist_q),
        .pc   (up_pc),
        .idx  (up_idx)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    assign lk_taken = lk_ctr[CTR_W-1];

    assert_idle_keeps_guess_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid && $stable(lk_pc)) |=> $stable(lk_taken) || $changed(lk_pc));

endmodule

// File: tb/sim_corr_branch_predictor.sv
module sim_corr_branch_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_taken;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0] ref_ctr [64];
    logic [1:0] ref_hist;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    corr_branch_predictor u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .up_valid (up_valid),
        .up_pc    (up_pc),
        .up_taken (up_taken)
    );

    function automatic logic [5:0] ref_idx(input logic [31:0] pc);
        return {ref_hist, pc[5:2]};
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: lk_taken actual=%0b expected=%0b (pc=%h hist=%b)",
                     req, got, exp, lk_pc, ref_hist);
        end
    endtask

    task automatic model_update(input logic [31:0] pc, input logic t);
        logic [5:0] i;
        i = ref_idx(pc);
        if (t && ref_ctr[i] != 2'b11) ref_ctr[i] = ref_ctr[i] + 2'd1;
        if (!t && ref_ctr[i] != 2'b00) ref_ctr[i] = ref_ctr[i] - 2'd1;
        ref_hist = {ref_hist[0], t};
    endtask

    task automatic lookup(input logic [31:0] pc, input string req);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check(req, lk_taken, ref_ctr[ref_idx(pc)][1]);
    endtask

    task automatic lookup_exp(input logic [31:0] pc, input logic exp, input string req);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check(req, lk_taken, exp);
    endtask

    task automatic train(input logic [31:0] pc, input logic t);
        @(negedge clk);
        up_valid = 1'b1;
        up_pc    = pc;
        up_taken = t;
        @(posedge clk);
        #1;
        up_valid = 1'b0;
        model_update(pc, t);
    endtask

    task automatic sweep(input logic [31:0] hi, input string req);
        for (int r = 0; r < 16; r++) begin
            lookup(hi | (32'(r) << 2), req);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) ref_ctr[i] = 2'b01;
        ref_hist = 2'b00;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        do_reset();

        // R1: every row of bank 0 guesses not taken after reset.
        for (int r = 0; r < 16; r++) lookup_exp(32'(r) << 2, 1'b0, "R1");

        // R6 / R2: train row 3 of bank 3 to strong taken, one miss keeps taken.
        train(32'h0000_000C, 1'b1);  // bank0
        train(32'h0000_000C, 1'b1);  // bank1
        train(32'h0000_000C, 1'b1);  // bank3 -> 10
        train(32'h0000_000C, 1'b1);  // bank3 -> 11
        lookup_exp(32'h0000_000C, 1'b1, "R2");
        train(32'h0000_000C, 1'b0);  // bank3 -> 10, hist 10
        train(32'h0000_000C, 1'b1);  // bank2, hist 01
        train(32'h0000_000C, 1'b1);  // bank1, hist 11
        lookup_exp(32'h0000_000C, 1'b1, "R6");
        train(32'h0000_000C, 1'b0);  // bank3 -> 01
        train(32'h0000_000C, 1'b1);
        train(32'h0000_000C, 1'b1);  // hist 11
        lookup_exp(32'h0000_000C, 1'b0, "R6");
        sweep(32'h0, "R7");

        // R4: extra taken outcomes at the top stay saturated.
        do_reset();
        for (int k = 0; k < 8; k++) train(32'h0000_0010, 1'b1);
        lookup("32'h0000_0010" == "" ? 32'h0 : 32'h0000_0010, "R4");
        lookup_exp(32'h0000_0010, 1'b1, "R4");
        // R5: a run of not-taken outcomes floors at 00 in bank 0.
        for (int k = 0; k < 8; k++) train(32'h0000_0010, 1'b0);
        lookup_exp(32'h0000_0010, 1'b0, "R5");
        train(32'h0000_0010, 1'b1);  // bank0: 00 -> 01, still not taken
        train(32'h0000_0014, 1'b0);  // back to hist 10 ... keep model
        sweep(32'h0, "R5");

        // R9: high address bits do not change selection.
        do_reset();
        train(32'hFFFF_FF20, 1'b1);   // bank0 row 8 -> 10, hist 01
        train(32'h0000_0004, 1'b0);   // bank1 row 1, hist 10
        train(32'h1234_5604, 1'b0);   // bank2 row 1, hist 00
        lookup_exp(32'h0000_0020, 1'b1, "R9");
        lookup_exp(32'hABCD_0023, 1'b1, "R9");

        // R8: history bank selection after known shifts.
        train(32'h0000_0030, 1'b1);   // bank0 row 12 -> 10, hist 01
        lookup_exp(32'h0000_0030, 1'b0, "R8");   // bank1 row 12 still 01
        train(32'h0000_0000, 1'b0);   // hist 10
        train(32'h0000_0000, 1'b0);   // hist 00
        lookup_exp(32'h0000_0030, 1'b1, "R8");
        sweep(32'h0, "R3");

        // R10: same-cycle read and write of one entry returns the old value.
        @(negedge clk);
        lk_pc    = 32'h0000_0020;     // bank0 row 8 holds 10
        up_valid = 1'b1;
        up_pc    = 32'h0000_0020;
        up_taken = 1'b0;
        #1;
        check("R10", lk_taken, 1'b1);
        @(posedge clk);
        #1;
        up_valid = 1'b0;
        model_update(32'h0000_0020, 1'b0);
        sweep(32'h0, "R10");

        // R11: noise on update fields with up_valid low changes nothing.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            up_pc    = {lfsr, lfsr};
            up_taken = lfsr[0];
            lk_pc    = {lfsr[7:0], lfsr, lfsr[15:8]};
            lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        sweep(32'h0, "R11");

        // R3 R4 R5 R7 R8: long pseudo-random training, full row sweep each step.
        do_reset();
        for (int s = 0; s < 400; s++) begin
            logic [31:0] pc;
            logic        t;
            pc   = {lfsr[15:8], 16'h0, lfsr[7:4], 2'b00};
            t    = lfsr[1] | (lfsr[3] & lfsr[2]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            train(pc, t);
            sweep({lfsr[15:10], 26'h0}, "R3 R4 R5 R7 R8");
        end

        finish_run();
    end

endmodule